// File: doc/BRIEF.md
# Dual-Mode Binary Up Counter with Snapshot Register

This block counts falling edges arriving on asynchronous pulse pins. It runs entirely on one system clock. Every asynchronous pin first passes through a two-flop synchronizer and a falling-edge detector. The count register is `2*HALF_W` bits wide, which is 32 bits at the default setting. A static mode pin selects how the register behaves. With the pin low, the register is a single wide counter: the lower half carries into the upper half. With the pin high, the register holds two independent halves, and each half has its own pulse source.

The lower half counts falling edges of the logical AND of two gated pulse pins. Holding either of those pins low therefore blocks every edge on the other one. A third pulse pin acts on the upper half, and its meaning depends on the mode:
- In wide mode it is a test path. It bumps the upper half only while the top bit of the lower half is clear.
- In split mode it is the upper half's own count source.

An active-low clear pin zeroes the whole counter. An active-low load pin makes the snapshot register follow the counter. Once load is released, the snapshot register keeps its last value.

The block has no data stream, so no valid/ready handshake applies. All pins are plain levels, and the outputs are always valid.

Top module: `snapcnt_top`

## Requirements
- R1: After the synchronous system reset `rst_n` is released, `count_o` and `held_o` are both zero.
- R2: Each falling edge of (`lo_pulse_i` AND `alt_pulse_i`) adds one to the lower half. The change shows on `count_o` by the third rising clock edge after the input change. Nothing else changes the count.
- R3: While either `lo_pulse_i` or `alt_pulse_i` is held low, edges on the other pin do not change the count.
- R4: In wide mode (`split_i`=0), the lower half wrapping from all ones to zero carries one into the upper half. The full register wraps from all ones to zero.
- R5: In wide mode, a falling edge on `up_pulse_i` adds one to the upper half only when bit `HALF_W-1` of `count_o` is 0. Otherwise the count is left unchanged.
- R6: In split mode (`split_i`=1), each falling edge on `up_pulse_i` adds one to the upper half. Each half wraps to zero on its own, and no carry passes between the halves.
- R7: While the synchronized `clr_n_i` is low, both halves are zero. Clear wins over a count edge in the same cycle.
- R8: While `load_n_i` is low, `held_o` follows `count_o` one cycle behind. While `load_n_i` is high, `held_o` keeps its value.
- R9: Rising edges on the pulse pins never change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| lo_pulse_i | input | 1 | Lower-half pulse source, gated by `alt_pulse_i` |
| alt_pulse_i | input | 1 | Second gated lower-half pulse source |
| up_pulse_i | input | 1 | Upper-half pulse: test bump in wide mode, count source in split mode |
| clr_n_i | input | 1 | Asynchronous active-low counter clear |
| load_n_i | input | 1 | Asynchronous active-low snapshot follow |
| split_i | input | 1 | Static mode select: 0 = one wide counter, 1 = two halves |
| count_o | output | 2*HALF_W | Live count, upper half in the high bits |
| held_o | output | 2*HALF_W | Snapshot register |

## Verification
An input change is captured by the first rising edge. It reaches the edge detector at the second edge and lands in `count_o` at the third edge. `held_o` follows one edge after `count_o`, and a clear shows on `count_o` at the third edge as well. The bench changes one input on a falling clock edge and then waits six clock cycles with everything else still. Only then does it sample, on a falling edge, so each result is already due. The bench uses a small 4-bit-half configuration. This lets it sweep every value of the full 8-bit register and every lower-half value under the test path. All expected values are computed arithmetically from the requirements.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  // depth of every input synchronizer chain
  localparam int SYNC_DEPTH = 2;

  // asynchronous pins bundled in one vector for the synchronizer
  typedef struct packed {
    logic clr_n;
    logic load_n;
    logic up_pulse;
    logic alt_pulse;
    logic lo_pulse;
  } async_pins_t;

  localparam int ASYNC_W = $bits(async_pins_t);
endpackage

// File: rtl/snapcnt_sync.sv
module snapcnt_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // all pins idle high; reset the chain to that level so no false edge appears
  logic [DEPTH-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[DEPTH-2:0], d};
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/snapcnt_fall.sv
module snapcnt_fall #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fall[i] = lvl_q[i] & ~lvl[i];
  end
endmodule

// File: rtl/snapcnt_core.sv
module snapcnt_core #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                split,
  input  logic                clr,
  input  logic                lo_fall,
  input  logic                up_fall,
  output logic [2*HALF_W-1:0] count
);
  localparam int TOP = HALF_W - 1;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic lo_full, carry, hi_step;

  assign lo_full = &lo_q;
  // carry only in wide mode
  assign carry   = ~split & lo_fall & lo_full;
  // test path is gated by the lower top bit in wide mode; one step even if both fire
  assign hi_step = carry | (up_fall & (split | ~lo_q[TOP]));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_fall) lo_q <= lo_q + 1'b1;
      if (hi_step) hi_q <= hi_q + 1'b1;
    end
  end

  assign count = {hi_q, lo_q};

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R4
  carry_into_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !clr && lo_fall && lo_full) |=> (lo_q == '0 && hi_q == $past(hi_q) + 1'b1));

  // R6
  no_split_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !clr && lo_fall && lo_full && !up_fall) |=> (lo_q == '0 && hi_q == $past(hi_q)));

  // R5
  test_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !clr && up_fall && lo_q[TOP] && !lo_fall) |=> $stable(count));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !lo_fall && !up_fall) |=> $stable(count));
endmodule

// File: rtl/snapcnt_hold.sv
module snapcnt_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= d;
  end

  // R8
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (held == $past(d)));

  // R8
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held));
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
  import snapcnt_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_pulse_i,
  input  logic                alt_pulse_i,
  input  logic                up_pulse_i,
  input  logic                clr_n_i,
  input  logic                load_n_i,
  input  logic                split_i,
  output logic [2*HALF_W-1:0] count_o,
  output logic [2*HALF_W-1:0] held_o
);
  localparam int W = 2 * HALF_W;

  async_pins_t raw, syn;
  logic [1:0]  src_lvl, src_fall;

  assign raw = '{clr_n: clr_n_i, load_n: load_n_i, up_pulse: up_pulse_i,
                 alt_pulse: alt_pulse_i, lo_pulse: lo_pulse_i};

  snapcnt_sync #(.W(ASYNC_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  // lower source is the gated AND of its two pins
  assign src_lvl = {syn.up_pulse, syn.lo_pulse & syn.alt_pulse};

  snapcnt_fall #(.W(2)) u_fall (
    .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .fall(src_fall)
  );

  snapcnt_core #(.HALF_W(HALF_W)) u_core (
    .clk(clk), .rst_n(rst_n), .split(split_i), .clr(~syn.clr_n),
    .lo_fall(src_fall[0]), .up_fall(src_fall[1]), .count(count_o)
  );

  snapcnt_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(~syn.load_n), .d(count_o), .held(held_o)
  );
endmodule

// File: tb/sim_snapcnt_top.sv
module sim_snapcnt_top;
  localparam int HW   = 4;
  localparam int W    = 2 * HW;
  localparam int HMOD = 1 << HW;
  localparam int FMOD = 1 << W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lo, alt, up, clr_n, load_n, split;
  logic [W-1:0] count, held;
  int checks = 0, failures = 0;
  int exp_lo = 0, exp_hi = 0;
  logic lvl_ab = 1'b1;
  bit done = 1'b0;

  snapcnt_top #(.HALF_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .lo_pulse_i(lo), .alt_pulse_i(alt),
    .up_pulse_i(up), .clr_n_i(clr_n), .load_n_i(load_n), .split_i(split),
    .count_o(count), .held_o(held)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_cnt();
    return W'(exp_hi * HMOD + exp_lo);
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic model_lo_step();
    if (split) exp_lo = (exp_lo + 1) % HMOD;
    else begin
      int f = (exp_hi * HMOD + exp_lo + 1) % FMOD;
      exp_hi = f / HMOD;
      exp_lo = f % HMOD;
    end
  endtask

  task automatic drive_ab(input logic a, input logic b);
    if (lvl_ab && !(a && b)) model_lo_step();
    lvl_ab = a & b;
    lo = a;
    alt = b;
    settle();
  endtask

  task automatic pulse_lo();
    drive_ab(1'b0, alt);
    drive_ab(1'b1, alt);
  endtask

  task automatic pulse_up();
    up = 1'b0;
    if (split || ((exp_lo >> (HW - 1)) & 1) == 0) exp_hi = (exp_hi + 1) % HMOD;
    settle();
    up = 1'b1;
    settle();
  endtask

  task automatic do_clear();
    clr_n = 1'b0;
    settle();
    exp_lo = 0;
    exp_hi = 0;
    clr_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lo = 1'b1; alt = 1'b1; up = 1'b1;
    clr_n = 1'b1; load_n = 1'b1; split = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1
    check("R1 count", count, '0);
    check("R1 held", held, '0);

    // R2 / R4: full sweep of the wide register including its wrap
    for (int k = 0; k < FMOD + 4; k++) begin
      pulse_lo();
      check(exp_lo == 0 ? "R4 carry/wrap" : "R2 step", count, exp_cnt());
    end

    // R9: rising edge alone does not count
    drive_ab(1'b0, 1'b1);
    check("R2 fall", count, exp_cnt());
    drive_ab(1'b1, 1'b1);
    check("R9 rise", count, exp_cnt());

    // R3: gate pin low blocks the other
    drive_ab(1'b1, 1'b0);
    check("R3 gate drop", count, exp_cnt());
    for (int k = 0; k < 3; k++) begin
      drive_ab(1'b0, 1'b0);
      check("R3 blocked low", count, exp_cnt());
      drive_ab(1'b1, 1'b0);
      check("R3 blocked high", count, exp_cnt());
    end
    drive_ab(1'b1, 1'b1);
    check("R9 gate rise", count, exp_cnt());

    // R8: snapshot untouched while load high
    check("R8 idle held", held, '0);

    // R5: test path across every lower value
    for (int v = 0; v < HMOD; v++) begin
      do_clear();
      for (int p = 0; p < v; p++) pulse_lo();
      pulse_up();
      check("R5 test path", count, exp_cnt());
    end

    // R7: clear and a count edge together; clear wins
    for (int k = 0; k < 5; k++) pulse_lo();
    clr_n = 1'b0;
    lo = 1'b0;
    lvl_ab = 1'b0;
    exp_lo = 0;
    exp_hi = 0;
    settle();
    check("R7 clear", count, '0);
    clr_n = 1'b1;
    settle();
    check("R7 after clear", count, '0);
    drive_ab(1'b1, 1'b1);
    check("R9 after clear", count, '0);

    // R6: split mode, independent halves and wraps
    split = 1'b1;
    do_clear();
    for (int k = 0; k < HMOD + 4; k++) begin
      pulse_lo();
      check("R6 lower", count, exp_cnt());
      if (k % 2 == 1) begin
        pulse_up();
        check("R6 upper", count, exp_cnt());
      end
    end
    for (int k = 0; k < HMOD; k++) begin
      pulse_up();
      check("R6 upper wrap", count, exp_cnt());
    end

    // R8: follow then keep
    split = 1'b0;
    do_clear();
    load_n = 1'b0;
    settle();
    for (int k = 0; k < 5; k++) begin
      pulse_lo();
      check("R8 follow", held, exp_cnt());
    end
    load_n = 1'b1;
    settle();
    begin
      logic [W-1:0] snap;
      snap = exp_cnt();
      for (int k = 0; k < 3; k++) pulse_lo();
      check("R8 keep", held, snap);
      check("R2 count after keep", count, exp_cnt());
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule